// File: doc/BRIEF.md
# Line Peak Detector With Fast Discharge

This block follows a stream of sampled, rectified mains codes and keeps a held level equal to the recent line peak. That level feeds a line-voltage feedforward path. It behaves like a diode that charges a hold capacitor, with a slow resistive bleed across the capacitor. A switched discharge path closes when the mains sags.

A rise in the line reaches the held level on the same sample. A sag is found at the end of each half-cycle, by comparing the running maximum of that half-cycle against the held level. When the held level sits too far above that peak, the block pulses a drop event and discharges quickly in fixed steps. The discharge stops once it meets the live line sample, or once it reaches a floor code that keeps the brownout comparator downstream from tripping. A soft-start request from the supervisor starts the same fast discharge.

Every state change happens only on a cycle with the sample strobe high, except the arming of fast discharge by soft-start.

Top module: `line_peak_hold`

## Requirements
- R1: On a valid sample whose code is greater than the held level, the held level takes the sample code at the next clock edge, up to full scale. This has priority over every other update, and it ends fast discharge.
- R2: Valid samples are counted from reset. On every BLEED_EVERY-th one, if the sample does not charge and fast discharge is off, the held level becomes `held - (held >> BLEED_SHIFT)`.
- R3: A half-cycle ends on the first valid sample with code at or below ZERO_TH that follows a sample above ZERO_TH. The running maximum then restarts from zero. Samples above ZERO_TH raise the running maximum.
- R4: At a half-cycle end, if the held level exceeds the running maximum plus DROP_TH, the drop output is high for exactly one cycle after that edge, and fast discharge is on from the same edge.
- R5: While fast discharge is on, each valid sample that does not charge lowers the held level by FAST_STEP.
- R6: If a fast step would bring the held level to or below the current sample code, the held level takes the sample code and fast discharge ends.
- R7: If a fast step would bring the held level to or below the floor code, the held level is set to the floor and fast discharge ends. If the held level is already at or below the floor, fast discharge ends and the held level does not change.
- R8: A soft-start request turns fast discharge on from the next clock edge.
- R9: While the sample strobe is low, the held level, the bleed count and the half-cycle state do not change.
- R10: After reset, the held level is zero and the fast-discharge and drop outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | A new line sample is present |
| line_i | input | W | Rectified line sample code |
| ss_req_i | input | 1 | Soft-start discharge request |
| floor_i | input | W | Brownout floor code |
| held_o | output | W | Held feedforward level |
| fast_o | output | 1 | Fast discharge active |
| drop_o | output | 1 | One-cycle line-drop event |

## Verification
The vector walk drives a rising half-sine, a flat zero stretch and a sagging second half-cycle. These separate the instant charge from the slow bleed, and a half-cycle whose peak is close to the held level from one that has really dropped. The discharge run ends three different ways: on the rising line, at the floor, and with the held level already under the floor. This shows that the stop conditions are checked in the right order. Further tests cover a full-scale surge, an idle stretch with a high line code on a low strobe, and a reset in the middle of the run.

// File: rtl/lph_pkg.sv
package lph_pkg;
    typedef enum logic [2:0] {
        UPD_KEEP,
        UPD_CHARGE,
        UPD_BLEED,
        UPD_FAST,
        UPD_MEET_LINE,
        UPD_AT_FLOOR,
        UPD_HALT
    } upd_e;
endpackage

// File: rtl/lph_bleed_timer.sv
module lph_bleed_timer #(
    parameter int BLEED_EVERY = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid_i,
    output logic tick_o
);
    localparam int CW = (BLEED_EVERY > 2) ? $clog2(BLEED_EVERY) : 1;
    localparam logic [CW-1:0] LAST = CW'(BLEED_EVERY - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = smp_valid_i && (cnt_q == LAST);
        if (smp_valid_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lph_halfcycle.sv
module lph_halfcycle #(
    parameter int W       = 12,
    parameter int ZERO_TH = 16,
    parameter int DROP_TH = 60
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid_i,
    input  logic [W-1:0] line_i,
    input  logic [W-1:0] held_i,
    output logic         drop_now_o,
    output logic         drop_o
);
    typedef struct packed {
        logic [W-1:0] pk;
        logic         armed;
        logic         drop;
    } hc_t;

    hc_t hc_d, hc_q;
    logic near_zero;
    logic [W:0] limit;

    always_comb begin
        hc_d       = hc_q;
        hc_d.drop  = 1'b0;
        near_zero  = (line_i <= W'(ZERO_TH));
        limit      = {1'b0, hc_q.pk} + (W+1)'(DROP_TH);
        drop_now_o = smp_valid_i && near_zero && hc_q.armed
                     && ({1'b0, held_i} > limit);
        if (smp_valid_i) begin
            if (near_zero) begin
                hc_d.pk    = '0;
                hc_d.armed = 1'b0;
            end else begin
                hc_d.armed = 1'b1;
                if (line_i > hc_q.pk) hc_d.pk = line_i;
            end
        end
        hc_d.drop = drop_now_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hc_q <= '0;
        else        hc_q <= hc_d;
    end

    assign drop_o = hc_q.drop;

    // R4: the event is a single-cycle pulse
    p_drop_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hc_q.drop |=> !hc_q.drop);
endmodule

// File: rtl/lph_hold.sv
module lph_hold
    import lph_pkg::*;
#(
    parameter int W           = 12,
    parameter int BLEED_SHIFT = 8,
    parameter int FAST_STEP   = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid_i,
    input  logic [W-1:0] line_i,
    input  logic [W-1:0] floor_i,
    input  logic         tick_i,
    input  logic         drop_now_i,
    input  logic         ss_req_i,
    output logic [W-1:0] held_o,
    output logic         fast_o
);
    typedef struct packed {
        logic [W-1:0] held;
        logic         fast;
    } hold_t;

    hold_t st_d, st_q;
    upd_e  upd;
    logic [W:0] stepped;

    always_comb begin
        st_d    = st_q;
        upd     = UPD_KEEP;
        stepped = {1'b0, st_q.held} - (W+1)'(FAST_STEP);
        if (smp_valid_i) begin
            if (line_i > st_q.held) begin
                upd = UPD_CHARGE;
            end else if (st_q.fast) begin
                if (st_q.held <= floor_i)                          upd = UPD_HALT;
                else if (stepped[W] || stepped[W-1:0] <= floor_i)  upd = UPD_AT_FLOOR;
                else if (stepped[W-1:0] <= line_i)                 upd = UPD_MEET_LINE;
                else                                               upd = UPD_FAST;
            end else if (tick_i) begin
                upd = UPD_BLEED;
            end
        end
        case (upd)
            UPD_CHARGE:    begin st_d.held = line_i;  st_d.fast = 1'b0; end
            UPD_BLEED:     st_d.held = st_q.held - (st_q.held >> BLEED_SHIFT);
            UPD_FAST:      st_d.held = stepped[W-1:0];
            UPD_MEET_LINE: begin st_d.held = line_i;  st_d.fast = 1'b0; end
            UPD_AT_FLOOR:  begin st_d.held = floor_i; st_d.fast = 1'b0; end
            UPD_HALT:      st_d.fast = 1'b0;
            default:       ;
        endcase
        if (drop_now_i || ss_req_i) st_d.fast = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o = st_q.held;
    assign fast_o = st_q.fast;

    p_charge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && line_i > st_q.held) |=> (st_q.held == $past(line_i)));
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_i |=> $stable(st_q.held));
    p_softstart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req_i |=> st_q.fast);
endmodule

// File: rtl/line_peak_hold.sv
module line_peak_hold #(
    parameter int W           = 12,
    parameter int BLEED_EVERY = 64,
    parameter int BLEED_SHIFT = 8,
    parameter int DROP_TH     = 60,
    parameter int ZERO_TH     = 16,
    parameter int FAST_STEP   = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid_i,
    input  logic [W-1:0] line_i,
    input  logic         ss_req_i,
    input  logic [W-1:0] floor_i,
    output logic [W-1:0] held_o,
    output logic         fast_o,
    output logic         drop_o
);
    logic tick, drop_now;
    logic [W-1:0] held;

    lph_bleed_timer #(.BLEED_EVERY(BLEED_EVERY)) u_timer (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .tick_o(tick));

    lph_halfcycle #(.W(W), .ZERO_TH(ZERO_TH), .DROP_TH(DROP_TH)) u_half (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .line_i(line_i),
        .held_i(held), .drop_now_o(drop_now), .drop_o(drop_o));

    lph_hold #(.W(W), .BLEED_SHIFT(BLEED_SHIFT), .FAST_STEP(FAST_STEP)) u_hold (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .line_i(line_i),
        .floor_i(floor_i), .tick_i(tick), .drop_now_i(drop_now),
        .ss_req_i(ss_req_i), .held_o(held), .fast_o(fast_o));

    assign held_o = held;

    // R4: a drop event always comes with fast discharge on
    p_drop_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> fast_o);
endmodule

// File: tb/sim_line_peak_hold.sv
module sim_line_peak_hold;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid = 1'b0;
    logic ss = 1'b0;
    logic [7:0] line = '0;
    logic [7:0] floor_c = 8'd40;
    logic [7:0] held;
    logic fast, drop;
    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    line_peak_hold #(.W(8), .BLEED_EVERY(4), .BLEED_SHIFT(3), .DROP_TH(10),
                     .ZERO_TH(2), .FAST_STEP(16)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(valid), .line_i(line),
        .ss_req_i(ss), .floor_i(floor_c), .held_o(held), .fast_o(fast),
        .drop_o(drop));

    typedef struct packed {
        logic [7:0] ln;
        logic       ssr;
        logic [7:0] e_held;
        logic       e_fast;
        logic       e_drop;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{8'd100,1'b0,8'd100,1'b0,1'b0}, '{8'd150,1'b0,8'd150,1'b0,1'b0},
        '{8'd200,1'b0,8'd200,1'b0,1'b0}, '{8'd150,1'b0,8'd175,1'b0,1'b0},
        '{8'd100,1'b0,8'd175,1'b0,1'b0}, '{8'd0,  1'b0,8'd175,1'b0,1'b0},
        '{8'd0,  1'b0,8'd175,1'b0,1'b0}, '{8'd120,1'b0,8'd154,1'b0,1'b0},
        '{8'd140,1'b0,8'd154,1'b0,1'b0}, '{8'd100,1'b0,8'd154,1'b0,1'b0},
        '{8'd1,  1'b0,8'd154,1'b1,1'b1}, '{8'd50, 1'b0,8'd138,1'b1,1'b0},
        '{8'd100,1'b0,8'd122,1'b1,1'b0}, '{8'd120,1'b0,8'd120,1'b0,1'b0},
        '{8'd130,1'b0,8'd130,1'b0,1'b0}, '{8'd0,  1'b0,8'd114,1'b0,1'b0},
        '{8'd0,  1'b1,8'd114,1'b1,1'b0}, '{8'd0,  1'b0,8'd98, 1'b1,1'b0},
        '{8'd0,  1'b0,8'd82, 1'b1,1'b0}, '{8'd0,  1'b0,8'd66, 1'b1,1'b0},
        '{8'd0,  1'b0,8'd50, 1'b1,1'b0}, '{8'd0,  1'b0,8'd40, 1'b0,1'b0},
        '{8'd0,  1'b0,8'd40, 1'b0,1'b0}, '{8'd0,  1'b0,8'd35, 1'b0,1'b0},
        '{8'd0,  1'b1,8'd35, 1'b1,1'b0}, '{8'd0,  1'b0,8'd35, 1'b0,1'b0},
        '{8'd255,1'b0,8'd255,1'b0,1'b0}, '{8'd0,  1'b0,8'd224,1'b0,1'b0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 2, 26:    return "R1 charge";
            3, 7, 23, 27:   return "R2 bleed";
            5, 15:          return "R3 half-cycle end";
            10:             return "R4 drop";
            11, 12:         return "R5 fast step";
            13:             return "R6 meet line";
            21, 25:         return "R7 floor";
            16, 24:         return "R8 soft-start";
            default:        return "R2 hold between ticks";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] eh,
                         input logic ef, input logic ed);
        n_cmp++;
        if (held !== eh || fast !== ef || drop !== ed) begin
            n_bad++;
            $display("FAIL %s: held=%0d fast=%0b drop=%0b expected held=%0d fast=%0b drop=%0b",
                     tag, held, fast, drop, eh, ef, ed);
        end
    endtask

    task automatic sample(input logic [7:0] ln, input logic s);
        @(negedge clk);
        valid = 1'b1; line = ln; ss = s;
        @(posedge clk);
        #1;
        valid = 1'b0; ss = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset state", 8'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (i == 26) begin
                // R9: strobe low with a high code must leave everything unchanged
                @(negedge clk);
                line = 8'd255;
                repeat (5) @(negedge clk);
                check("R9 idle strobe", 8'd35, 1'b0, 1'b0);
            end
            sample(VEC[i].ln, VEC[i].ssr);
            check(tag_of(i), VEC[i].e_held, VEC[i].e_fast, VEC[i].e_drop);
        end

        // R10: reset in mid-run clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid-run reset", 8'd0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1: first sample after reset charges straight to it
        sample(8'd77, 1'b0);
        check("R1 charge after reset", 8'd77, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule